// File: doc/BRIEF.md
# File Register Read-Modify-Write Execute Stage

This block is the execute stage for byte-oriented register instructions of a small 8-bit core. It owns the working register (W), a file register array reached by a 7-bit address, and the zero, carry and digit-carry status flags. Every instruction it receives has already been decoded into an operation code, a file address and a one-bit destination select.

For each valid instruction the block reads the addressed file register and raises a read strobe with the address and the value read. This lets side-effecting registers outside the block see the access. It combines the value read with W through the selected operation. At the clock edge that closes the instruction cycle, it stores the result either in W or back in the same file register and updates the flags that the operation affects. The read happens even for operations that only write the register, such as the W-to-file move and the clear. The core issues at most one instruction per clock cycle.

Top module: `rmw_exec`

## Requirements
- R1: After a synchronous active-low reset, W is 0x00, all three flags are 0 and every file register reads 0x00.
- R2: In every cycle with `ins_valid` high, `rd_stb` is 1 and `rd_addr` equals `ins_faddr`. This holds for every operation code, including write-only, clear and reserved codes. In cycles with `ins_valid` low, `rd_stb` is 0.
- R3: With `ins_dest` = 0 the result is written to W and the file register keeps its value. With `ins_dest` = 1 the result is written to the addressed file register and W keeps its value.
- R4: `rd_data` shows the file register contents as they stand before the instruction. The write happens once, at the clock edge that ends the cycle, so a following read sees the new value.
- R5: Operation code 1 (add) produces F+W modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R6: Operation code 2 (subtract) produces F−W modulo 256. C=1 exactly when F ≥ W (no borrow). DC=1 exactly when F[3:0] ≥ W[3:0]. Z is set when the result is zero.
- R7: These operations change only Z and leave C and DC unchanged: code 0 move (F), 3 and (F&W), 4 or (F|W), 5 xor (F^W), 6 increment (F+1), 7 decrement (F−1) and 8 complement (~F).
- R8: Code 9 (clear) produces 0x00 and sets Z. Code 10 (move W to file) produces W and changes no flag.
- R9: With `ins_valid` low, W, the flags and every file register keep their values.
- R10: Codes 11 to 15 are reserved. They write neither W nor any file register and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | A decoded instruction is present this cycle |
| ins_op | input | 4 | Operation code |
| ins_faddr | input | 7 | File register address |
| ins_dest | input | 1 | Destination select: 0 = W, 1 = file register |
| rd_stb | output | 1 | File register read strobe |
| rd_addr | output | 7 | Address being read |
| rd_data | output | 8 | Value read from the file register |
| w_out | output | 8 | Current W contents |
| z_flag | output | 1 | Zero flag |
| c_flag | output | 1 | Carry / no-borrow flag |
| dc_flag | output | 1 | Digit-carry / nibble no-borrow flag |

## Verification
The assertions assume that the instruction fields are known values whenever `ins_valid` is high. They also assume that exactly one instruction is presented per cycle, with no stall or hold of a partial operation. The stimulus changes the inputs only on the falling clock edge and always drives defined codes, including the reserved range. It mixes idle cycles with random instructions that favour a small set of addresses, so that values written earlier are read back and combined with W.

// File: rtl/rmw_pkg.sv
// Package: shared widths and the operation code type of the execute stage.
// Assumes a byte datapath whose half-carry comes out of the low nibble.
package rmw_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int NIB_W  = 4;

    typedef enum logic [3:0] {
        OP_MOVF  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_COM   = 4'd8,
        OP_CLR   = 4'd9,
        OP_MOVWF = 4'd10
    } op_e;
endpackage

// File: rtl/rmw_regfile.sv
// Module: file register array with one asynchronous read port and one
// synchronous write port. Each entry is its own register with its own
// write enable. Assumes at most one write per cycle.
module rmw_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_entry
            // Hold one entry; load it when the write targets this index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[gi] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(gi)))
                    mem[gi] <= wr_data;
            end
        end
    endgenerate

    // Present the addressed entry as it stands before any write this cycle.
    always_comb rd_data = mem[rd_addr];

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/rmw_alu.sv
// Module: combinational operation unit. It takes the value read from the
// file register (f) and W, and returns the result, the candidate flags,
// which flags the operation updates, and whether a write-back is due.
// Assumes op is a defined value whenever the caller uses the outputs.
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DW = 8,
    parameter int NW = 4
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] f,
    input  logic [DW-1:0] w,
    output logic [DW-1:0] res,
    output logic          wr,
    output logic          upd_z,
    output logic          upd_cd,
    output logic          z_n,
    output logic          c_n,
    output logic          dc_n
);
    localparam logic [DW:0] ONE_W = (DW+1)'(1);
    localparam logic [NW:0] ONE_N = (NW+1)'(1);

    logic [DW:0] add_full, sub_full;
    logic [NW:0] add_nib, sub_nib;

    // Wide adders expose the carry out of the top bit and of the low nibble.
    always_comb begin
        add_full = {1'b0, f} + {1'b0, w};
        sub_full = {1'b0, f} + {1'b0, ~w} + ONE_W;
        add_nib  = {1'b0, f[NW-1:0]} + {1'b0, w[NW-1:0]};
        sub_nib  = {1'b0, f[NW-1:0]} + {1'b0, ~w[NW-1:0]} + ONE_N;
    end

    // Select the result and which flags the operation touches.
    always_comb begin
        res    = '0;
        wr     = 1'b1;
        upd_z  = 1'b1;
        upd_cd = 1'b0;
        c_n    = 1'b0;
        dc_n   = 1'b0;
        case (op_e'(op))
            OP_MOVF:  res = f;
            OP_ADD: begin
                res    = add_full[DW-1:0];
                upd_cd = 1'b1;
                c_n    = add_full[DW];
                dc_n   = add_nib[NW];
            end
            OP_SUB: begin
                res    = sub_full[DW-1:0];
                upd_cd = 1'b1;
                c_n    = sub_full[DW];
                dc_n   = sub_nib[NW];
            end
            OP_AND:   res = f & w;
            OP_OR:    res = f | w;
            OP_XOR:   res = f ^ w;
            OP_INC:   res = f + DW'(1);
            OP_DEC:   res = f - DW'(1);
            OP_COM:   res = ~f;
            OP_CLR:   res = '0;
            OP_MOVWF: begin
                res   = w;
                upd_z = 1'b0;
            end
            default: begin
                wr    = 1'b0;
                upd_z = 1'b0;
            end
        endcase
    end

    // The zero flag candidate follows the selected result.
    always_comb z_n = (res == '0);
endmodule

// File: rtl/rmw_status.sv
// Module: zero, carry and digit-carry flag registers. A flag loads only
// when its update enable is high; otherwise it holds its value.
module rmw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_z,
    input  logic upd_cd,
    input  logic z_n,
    input  logic c_n,
    input  logic dc_n,
    output logic z_q,
    output logic c_q,
    output logic dc_q
);
    // Zero flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)     z_q <= 1'b0;
        else if (upd_z) z_q <= z_n;
    end

    // Carry and digit-carry registers, updated together by add and subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q  <= 1'b0;
            dc_q <= 1'b0;
        end else if (upd_cd) begin
            c_q  <= c_n;
            dc_q <= dc_n;
        end
    end

    p_cd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_cd |=> ($stable(c_q) && $stable(dc_q)));
endmodule

// File: rtl/rmw_exec.sv
// Module: execute stage top. It reads the addressed file register in the
// same cycle the instruction is valid, runs the operation with W, and
// commits the result to W or to the file register at the closing edge.
// Assumes one fully decoded instruction per cycle.
module rmw_exec
    import rmw_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [3:0]    ins_op,
    input  logic [AW-1:0] ins_faddr,
    input  logic          ins_dest,
    output logic          rd_stb,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] w_out,
    output logic          z_flag,
    output logic          c_flag,
    output logic          dc_flag
);
    logic [DW-1:0] w_q, f_val, alu_res;
    logic alu_wr, alu_upd_z, alu_upd_cd, alu_z, alu_c, alu_dc;
    logic file_we, w_we;

    // Read strobe and address go out on every valid instruction.
    always_comb begin
        rd_stb  = ins_valid;
        rd_addr = ins_faddr;
        rd_data = f_val;
    end

    // Route the write-back by the destination select.
    always_comb begin
        file_we = ins_valid && alu_wr && ins_dest;
        w_we    = ins_valid && alu_wr && !ins_dest;
    end

    rmw_regfile #(.DATA_W(DW), .ADDR_W(AW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(ins_faddr), .rd_data(f_val),
        .wr_en(file_we), .wr_addr(ins_faddr), .wr_data(alu_res)
    );

    rmw_alu #(.DW(DW), .NW(NW)) u_alu (
        .op(ins_op), .f(f_val), .w(w_q), .res(alu_res),
        .wr(alu_wr), .upd_z(alu_upd_z), .upd_cd(alu_upd_cd),
        .z_n(alu_z), .c_n(alu_c), .dc_n(alu_dc)
    );

    rmw_status u_st (
        .clk(clk), .rst_n(rst_n),
        .upd_z(ins_valid && alu_upd_z), .upd_cd(ins_valid && alu_upd_cd),
        .z_n(alu_z), .c_n(alu_c), .dc_n(alu_dc),
        .z_q(z_flag), .c_q(c_flag), .dc_q(dc_flag)
    );

    // Working register, loaded when W is the destination.
    always_ff @(posedge clk) begin
        if (!rst_n)    w_q <= '0;
        else if (w_we) w_q <= alu_res;
    end

    always_comb w_out = w_q;

    p_file_dest_keeps_w_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_dest) |=> $stable(w_q));
    p_w_dest_takes_res_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_dest && alu_wr) |=> (w_q == $past(alu_res)));
    p_idle_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> ($stable(w_q) && $stable(z_flag) && $stable(c_flag)));
    p_clr_sets_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_op == 4'd9) |=> z_flag);
endmodule

// File: tb/rmw_exec_test.sv
`timescale 1ns/1ps
module rmw_exec_test;
    localparam time TCK = 20ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_valid = 1'b0, ins_dest = 1'b0;
    logic [3:0] ins_op = '0;
    logic [6:0] ins_faddr = '0;
    logic rd_stb, z_flag, c_flag, dc_flag;
    logic [6:0] rd_addr;
    logic [7:0] rd_data, w_out;

    int total = 0, fails = 0;
    bit done = 1'b0;

    logic [7:0] mdl [128];
    logic [7:0] mw;
    logic mz, mc, mdc;

    always #(TCK/2) clk = ~clk;

    rmw_exec uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_state(input string req);
        chk(w_out == mw, req, w_out, mw);
        chk({z_flag, c_flag, dc_flag} == {mz, mc, mdc}, req,
            {z_flag, c_flag, dc_flag}, {mz, mc, mdc});
    endtask

    function automatic string op_req(input logic [3:0] op);
        case (op)
            4'd1: return "R5";
            4'd2: return "R6";
            4'd9, 4'd10: return "R8";
            default: return (op > 4'd10) ? "R10" : "R7";
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic run(input logic [3:0] op, input logic [6:0] a, input logic d);
        logic [7:0] f, r;
        logic wr;
        f = mdl[a];
        ins_valid = 1'b1; ins_op = op; ins_faddr = a; ins_dest = d;
        #1;
        chk(rd_stb == 1'b1, "R2", rd_stb, 1);
        chk(rd_addr == a, "R2", rd_addr, a);
        chk(rd_data == f, "R4", rd_data, f);
        wr = 1'b1; r = 8'h00;
        case (op)
            4'd0: r = f;
            4'd1: begin r = f + mw; mc = (9'(f) + 9'(mw)) > 9'd255;
                        mdc = (5'(f[3:0]) + 5'(mw[3:0])) > 5'd15; end
            4'd2: begin r = f - mw; mc = f >= mw; mdc = f[3:0] >= mw[3:0]; end
            4'd3: r = f & mw;
            4'd4: r = f | mw;
            4'd5: r = f ^ mw;
            4'd6: r = f + 8'd1;
            4'd7: r = f - 8'd1;
            4'd8: r = ~f;
            4'd9: r = 8'h00;
            4'd10: r = mw;
            default: wr = 1'b0;
        endcase
        if (wr && op != 4'd10) mz = (r == 8'h00);
        if (wr) begin
            if (d) mdl[a] = r;
            else mw = r;
        end
        @(negedge clk);
        chk_state(d ? {op_req(op), "/R3"} : op_req(op));
    endtask

    task automatic idle_cycle();
        ins_valid = 1'b0;
        ins_op = 4'($urandom % 16);
        ins_faddr = 7'($urandom);
        ins_dest = 1'($urandom);
        #1;
        chk(rd_stb == 1'b0, "R2", rd_stb, 0);
        @(negedge clk);
        chk_state("R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
        mw = 8'h00; mz = 1'b0; mc = 1'b0; mdc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of W and flags, then file contents via reads.
        chk_state("R1");
        for (int i = 0; i < 128; i += 9) run(4'd0, 7'(i), 1'b1);

        // Directed: add overflow with both carries (R5).
        run(4'd8, 7'd0, 1'b1);           // file0 = 0xFF
        run(4'd6, 7'd1, 1'b0);           // W = 1
        run(4'd1, 7'd0, 1'b1);           // 0xFF+1 -> 0, C, DC, Z
        chk(mdl[0] == 8'h00 && z_flag && c_flag && dc_flag, "R5",
            {z_flag, c_flag, dc_flag}, 3'b111);
        // Subtract equal and borrow cases (R6).
        run(4'd6, 7'd2, 1'b1);           // file2 = 1
        run(4'd2, 7'd2, 1'b0);           // 1-1 = 0 into W
        run(4'd2, 7'd3, 1'b1);           // 0-0 = 0
        run(4'd10, 7'd4, 1'b1);          // W move to file (no flags) R8
        run(4'd8, 7'd5, 1'b0);           // W = 0xFF
        run(4'd2, 7'd2, 1'b1);           // 1-0xFF borrow
        // Clear, reserved, write-only read strobe (R8, R10, R2).
        run(4'd9, 7'd5, 1'b1);
        run(4'd12, 7'd2, 1'b1);
        run(4'd15, 7'd2, 1'b0);
        run(4'd0, 7'd2, 1'b1);
        idle_cycle();
        idle_cycle();
        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] a;
            a = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 8);
            if ($urandom % 10 == 0) idle_cycle();
            else run(4'($urandom % 16), a, 1'($urandom));
        end
        // Final sweep of the favoured addresses confirms file contents (R3).
        for (int i = 0; i < 8; i++) run(4'd0, 7'(i), 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule